// File: doc/BRIEF.md
# Composite Sync Pulse Classifier

This block watches an active-low composite sync input that is sampled on the pixel clock. It measures how long each low pulse lasts and sorts the pulse by that width alone. A pulse is either a line sync, a short glitch pulse, a long vertical pulse, or a width that fits none of those windows. From this decoding it drives a line strobe and a frame strobe, a running line number, and a flag that marks lines inside a fixed vertical window. A capture stage can use these outputs where it would otherwise need separate horizontal and vertical sync pins.

The vertical sequence is a glitch pulse, then three long pulses, then another glitch, and then ordinary line pulses again. The frame strobe fires when the third consecutive long pulse ends, and it returns the line number to zero. Each line pulse after that raises the line number by one. All outputs are plain registered signals with no handshake. The strobes are single-cycle pulses, so a consumer that needs them must watch every cycle, because the block has no way to hold them back.

Top module: `csync_classifier`

## Requirements
- R1: While reset is held and after it is released, before any pulse arrives, line_start, frame_start, width_err and line_active are 0 and line_num is 0.
- R2: A low pulse whose width is 150 to 162 clocks gives exactly one line_start pulse. The width is the number of rising clock edges at which csync_n is sampled 0. The pulse comes on the second rising edge after the first edge that samples csync_n high. line_num rises by one in the same cycle.
- R3: A low pulse of 8 to 16 clocks is a glitch. It gives no strobe and no width_err, and it leaves line_num and line_active unchanged.
- R4: A low pulse longer than 1000 clocks is a long pulse. The third long pulse in a row gives one frame_start pulse and sets line_num to 0 in the same cycle. The first and second long pulses give no strobe.
- R5: A low pulse of any other width (for example 7, 17, 149 or 163 clocks) gives a one-cycle width_err pulse, with the same latency as R2, and leaves line_num unchanged.
- R6: A line pulse or an error pulse between long pulses restarts the long-pulse run, so three more long pulses are needed for frame_start. A glitch between long pulses does not restart the run.
- R7: line_active is 1 exactly while line_num lies from 63 to 206 inclusive, which is 144 lines, and it changes in the same cycle as line_num.
- R8: line_num stops at its largest value, 511 by default, and further line pulses leave it there.
- R9: line_start, frame_start and width_err each last one cycle, and no two of them are high at once.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pixel clock; csync_n is sampled on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| csync_n | input | 1 | Composite sync, low during sync pulses |
| line_start | output | 1 | One-cycle strobe after a line-width pulse ends |
| frame_start | output | 1 | One-cycle strobe after the third consecutive long pulse ends |
| width_err | output | 1 | One-cycle strobe after a pulse whose width fits no window |
| line_num | output | LINE_W (9) | Lines counted since the last frame_start, saturating |
| line_active | output | 1 | High while line_num lies inside the active vertical window |

## Verification
A fault in the width counter shows up two cycles after the sync rises, as the wrong one of the three strobes. That makes every tolerance boundary visible within the pulse that crosses it. A long-pulse run counter that fails to restart, or that restarts when it should not, shows up as a missing or extra frame_start within one vertical sequence. A line counter that is off shows at the very next line_start through line_num. It also shows through the cycle in which line_active rises or falls at the window edges.

// File: rtl/csync_pkg.sv
package csync_pkg;
  typedef enum logic [1:0] {
    PK_LINE   = 2'd0,
    PK_GLITCH = 2'd1,
    PK_LONG   = 2'd2,
    PK_BAD    = 2'd3
  } pulse_kind_e;
endpackage

// File: rtl/csync_width_meter.sv
module csync_width_meter #(
  parameter int CNT_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sync_n,
  output logic             meas_valid,
  output logic [CNT_W-1:0] meas_width
);
  localparam logic [CNT_W-1:0] CNT_ONE = 1;

  logic             sync_q;
  logic [CNT_W-1:0] low_cnt;

  // Counts edges that sample the sync low; reports on the first high sample.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q     <= 1'b1;
      low_cnt    <= '0;
      meas_valid <= 1'b0;
      meas_width <= '0;
    end else begin
      sync_q     <= sync_n;
      meas_valid <= 1'b0;
      if (!sync_n) begin
        if (low_cnt != '1) low_cnt <= low_cnt + CNT_ONE;
      end else if (!sync_q) begin
        meas_valid <= 1'b1;
        meas_width <= low_cnt;
        low_cnt    <= '0;
      end
    end
  end
endmodule

// File: rtl/csync_kind_decoder.sv
module csync_kind_decoder
  import csync_pkg::*;
#(
  parameter int CNT_W      = 12,
  parameter int LINE_MIN   = 150,
  parameter int LINE_MAX   = 162,
  parameter int GLITCH_MIN = 8,
  parameter int GLITCH_MAX = 16,
  parameter int LONG_MIN   = 1001
) (
  input  logic [CNT_W-1:0] width,
  output pulse_kind_e      kind
);
  localparam logic [CNT_W-1:0] L_LO = CNT_W'(LINE_MIN);
  localparam logic [CNT_W-1:0] L_HI = CNT_W'(LINE_MAX);
  localparam logic [CNT_W-1:0] G_LO = CNT_W'(GLITCH_MIN);
  localparam logic [CNT_W-1:0] G_HI = CNT_W'(GLITCH_MAX);
  localparam logic [CNT_W-1:0] V_LO = CNT_W'(LONG_MIN);

  always_comb begin
    if (width >= L_LO && width <= L_HI)      kind = PK_LINE;
    else if (width >= G_LO && width <= G_HI) kind = PK_GLITCH;
    else if (width >= V_LO)                  kind = PK_LONG;
    else                                     kind = PK_BAD;
  end
endmodule

// File: rtl/csync_frame_tracker.sv
module csync_frame_tracker
  import csync_pkg::*;
#(
  parameter int LINE_W          = 9,
  parameter int LONGS_PER_FRAME = 3,
  parameter int ACT_FIRST       = 63,
  parameter int ACT_LINES       = 144
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              meas_valid,
  input  pulse_kind_e       kind,
  output logic              line_start,
  output logic              frame_start,
  output logic              width_err,
  output logic [LINE_W-1:0] line_num,
  output logic              line_active
);
  localparam int RUN_W = $clog2(LONGS_PER_FRAME + 1);
  localparam logic [RUN_W-1:0]  RUN_LAST = RUN_W'(LONGS_PER_FRAME - 1);
  localparam logic [RUN_W-1:0]  RUN_ONE  = 1;
  localparam logic [LINE_W-1:0] NUM_ONE  = 1;
  localparam logic [LINE_W:0]   WIN_LO   = (LINE_W + 1)'(ACT_FIRST);
  localparam logic [LINE_W:0]   WIN_HI   = (LINE_W + 1)'(ACT_FIRST + ACT_LINES);

  logic [RUN_W-1:0]  long_run, run_nxt;
  logic [LINE_W-1:0] num_nxt;
  logic              ls_nxt, fs_nxt, er_nxt;

  always_comb begin
    run_nxt = long_run;
    num_nxt = line_num;
    ls_nxt  = 1'b0;
    fs_nxt  = 1'b0;
    er_nxt  = 1'b0;
    if (meas_valid) begin
      unique case (kind)
        PK_LINE: begin
          ls_nxt  = 1'b1;
          run_nxt = '0;
          if (line_num != '1) num_nxt = line_num + NUM_ONE;
        end
        PK_GLITCH: begin
          run_nxt = long_run;
        end
        PK_LONG: begin
          if (long_run == RUN_LAST) begin
            fs_nxt  = 1'b1;
            run_nxt = '0;
            num_nxt = '0;
          end else begin
            run_nxt = long_run + RUN_ONE;
          end
        end
        default: begin
          er_nxt  = 1'b1;
          run_nxt = '0;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      long_run    <= '0;
      line_num    <= '0;
      line_active <= 1'b0;
      line_start  <= 1'b0;
      frame_start <= 1'b0;
      width_err   <= 1'b0;
    end else begin
      long_run    <= run_nxt;
      line_num    <= num_nxt;
      line_active <= ({1'b0, num_nxt} >= WIN_LO) && ({1'b0, num_nxt} < WIN_HI);
      line_start  <= ls_nxt;
      frame_start <= fs_nxt;
      width_err   <= er_nxt;
    end
  end
endmodule

// File: rtl/csync_classifier.sv
module csync_classifier
  import csync_pkg::*;
#(
  parameter int CNT_W           = 12,
  parameter int LINE_W          = 9,
  parameter int LINE_MIN        = 150,
  parameter int LINE_MAX        = 162,
  parameter int GLITCH_MIN      = 8,
  parameter int GLITCH_MAX      = 16,
  parameter int LONG_MIN        = 1001,
  parameter int LONGS_PER_FRAME = 3,
  parameter int ACT_FIRST       = 63,
  parameter int ACT_LINES       = 144
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              csync_n,
  output logic              line_start,
  output logic              frame_start,
  output logic              width_err,
  output logic [LINE_W-1:0] line_num,
  output logic              line_active
);
  logic             meas_valid;
  logic [CNT_W-1:0] meas_width;
  pulse_kind_e      kind;

  csync_width_meter #(.CNT_W(CNT_W)) u_meter (
    .clk        (clk),
    .rst_n      (rst_n),
    .sync_n     (csync_n),
    .meas_valid (meas_valid),
    .meas_width (meas_width)
  );

  csync_kind_decoder #(
    .CNT_W      (CNT_W),
    .LINE_MIN   (LINE_MIN),
    .LINE_MAX   (LINE_MAX),
    .GLITCH_MIN (GLITCH_MIN),
    .GLITCH_MAX (GLITCH_MAX),
    .LONG_MIN   (LONG_MIN)
  ) u_decode (
    .width (meas_width),
    .kind  (kind)
  );

  csync_frame_tracker #(
    .LINE_W          (LINE_W),
    .LONGS_PER_FRAME (LONGS_PER_FRAME),
    .ACT_FIRST       (ACT_FIRST),
    .ACT_LINES       (ACT_LINES)
  ) u_track (
    .clk         (clk),
    .rst_n       (rst_n),
    .meas_valid  (meas_valid),
    .kind        (kind),
    .line_start  (line_start),
    .frame_start (frame_start),
    .width_err   (width_err),
    .line_num    (line_num),
    .line_active (line_active)
  );
endmodule

// File: rtl/csync_classifier_chk.sv
module csync_classifier_chk #(
  parameter int LINE_W    = 9,
  parameter int ACT_FIRST = 63,
  parameter int ACT_LINES = 144
) (
  input logic              clk,
  input logic              rst_n,
  input logic              csync_n,
  input logic              line_start,
  input logic              frame_start,
  input logic              width_err,
  input logic [LINE_W-1:0] line_num,
  input logic              line_active
);
  localparam logic [LINE_W-1:0] NUM_MAX = '1;
  localparam logic [LINE_W-1:0] NUM_ONE = 1;
  localparam int ACT_END = ACT_FIRST + ACT_LINES;

  // R9: strobes never coincide
  p_strobes_excl_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({line_start, frame_start, width_err}) <= 1);

  // R9: each strobe lasts one cycle
  p_line_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
    line_start |=> !line_start);
  p_err_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
    width_err |=> !width_err);

  // R2: line strobe follows a sync rise by two edges
  p_line_after_rise_r2: assert property (@(posedge clk) disable iff (!rst_n)
    line_start |-> ($past(csync_n, 2) && !$past(csync_n, 3)));

  // R2, R8: line number steps by one or holds at the ceiling
  p_line_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    line_start |-> ((line_num == $past(line_num) + NUM_ONE) ||
                    (line_num == NUM_MAX && $past(line_num) == NUM_MAX)));

  // R4: frame strobe arrives with a cleared line number
  p_frame_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |-> (line_num == '0));

  // R3, R5: line number moves only with a strobe
  p_num_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!line_start && !frame_start) |-> $stable(line_num));

  // R7: active flag tracks the vertical window
  p_window_r7: assert property (@(posedge clk) disable iff (!rst_n)
    line_active == ((int'(line_num) >= ACT_FIRST) && (int'(line_num) < ACT_END)));
endmodule

bind csync_classifier csync_classifier_chk #(
  .LINE_W    (LINE_W),
  .ACT_FIRST (ACT_FIRST),
  .ACT_LINES (ACT_LINES)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .csync_n     (csync_n),
  .line_start  (line_start),
  .frame_start (frame_start),
  .width_err   (width_err),
  .line_num    (line_num),
  .line_active (line_active)
);

// File: tb/tb_csync_classifier.sv
module tb_csync_classifier;
  localparam int LINE_W = 9;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              csync_n = 1'b1;
  logic              line_start, frame_start, width_err, line_active;
  logic [LINE_W-1:0] line_num;

  int n_chk = 0, n_bad = 0;
  int n_line = 0, n_frame = 0, n_err = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  csync_classifier dut (
    .clk(clk), .rst_n(rst_n), .csync_n(csync_n),
    .line_start(line_start), .frame_start(frame_start), .width_err(width_err),
    .line_num(line_num), .line_active(line_active)
  );

  always @(negedge clk) if (rst_n) begin
    if (line_start)  n_line++;
    if (frame_start) n_frame++;
    if (width_err)   n_err++;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic pulse(input int low, input int high = 4);
    @(negedge clk) csync_n = 1'b0;
    repeat (low) @(negedge clk);
    csync_n = 1'b1;
    repeat (high - 1) @(negedge clk);
  endtask

  task automatic vert_seq();
    pulse(11);
    repeat (3) pulse(1884);
    pulse(12);
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk(line_start == 0 && frame_start == 0 && width_err == 0, "R1 strobes", 0, 0);
    chk(line_num == 0, "R1 line_num", int'(line_num), 0);
    chk(line_active == 0, "R1 line_active", int'(line_active), 0);
  endtask

  task automatic t_latency();
    logic a, b, c;
    @(negedge clk) csync_n = 1'b0;
    repeat (156) @(negedge clk);
    csync_n = 1'b1;
    @(negedge clk) a = line_start;
    @(negedge clk) b = line_start;
    @(negedge clk) c = line_start;
    chk(!a && b && !c, "R2 latency/R9 single", {a, b, c}, 3'b010);
    chk(line_num == 1, "R2 increment", int'(line_num), 1);
  endtask

  task automatic t_line_edges();
    int l0 = n_line, e0 = n_err, num0 = int'(line_num);
    pulse(150); pulse(162);
    chk(n_line == l0 + 2 && n_err == e0, "R2 150/162 lines", n_line - l0, 2);
    chk(int'(line_num) == num0 + 2, "R2 line_num", int'(line_num), num0 + 2);
    pulse(149); pulse(163);
    chk(n_err == e0 + 2 && n_line == l0 + 2, "R5 149/163 errors", n_err - e0, 2);
    chk(int'(line_num) == num0 + 2, "R5 line_num kept", int'(line_num), num0 + 2);
  endtask

  task automatic t_glitch();
    int l0 = n_line, e0 = n_err, num0 = int'(line_num);
    pulse(8); pulse(12); pulse(16);
    chk(n_line == l0 && n_err == e0 && n_frame == 0, "R3 glitch silent", n_line - l0 + n_err - e0, 0);
    chk(int'(line_num) == num0, "R3 line_num kept", int'(line_num), num0);
    pulse(7); pulse(17);
    chk(n_err == e0 + 2, "R5 7/17 errors", n_err - e0, 2);
  endtask

  task automatic t_frame();
    int f0 = n_frame;
    pulse(11); pulse(1884); pulse(1884);
    chk(n_frame == f0, "R4 no early frame", n_frame - f0, 0);
    pulse(1884);
    chk(n_frame == f0 + 1, "R4 frame on third", n_frame - f0, 1);
    chk(line_num == 0, "R4 line_num cleared", int'(line_num), 0);
    pulse(12);
    chk(n_frame == f0 + 1 && line_num == 0, "R3 trailing glitch", int'(line_num), 0);
  endtask

  task automatic t_run_restart();
    int f0 = n_frame;
    pulse(1884); pulse(1884); pulse(156); pulse(1884);
    chk(n_frame == f0, "R6 line restarts run", n_frame - f0, 0);
    pulse(1884); pulse(1884);
    chk(n_frame == f0 + 1, "R6 fresh run frames", n_frame - f0, 1);
    pulse(1884); pulse(1884); pulse(50); pulse(1884);
    chk(n_frame == f0 + 1, "R6 error restarts run", n_frame - f0, 1);
    pulse(1884); pulse(1884);
    chk(n_frame == f0 + 2, "R6 run after error", n_frame - f0, 2);
    pulse(1884); pulse(10); pulse(1884); pulse(1884);
    chk(n_frame == f0 + 3, "R6 glitch keeps run", n_frame - f0, 3);
  endtask

  task automatic t_window();
    int mism = 0;
    vert_seq();
    for (int k = 1; k <= 520; k++) begin
      bit exp_act;
      int exp_num;
      pulse(156);
      exp_act = (k >= 63 && k <= 206);
      exp_num = (k > 511) ? 511 : k;
      if (line_active != exp_act || int'(line_num) != exp_num) mism++;
      if (k == 62 || k == 63 || k == 206 || k == 207)
        chk(line_active == exp_act, $sformatf("R7 edge line %0d", k), int'(line_active), int'(exp_act));
    end
    chk(mism == 0, "R7 window sweep", mism, 0);
    chk(line_num == 9'd511, "R8 saturation", int'(line_num), 511);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_reset();
    t_latency();
    t_line_edges();
    t_glitch();
    t_frame();
    t_run_restart();
    t_window();
    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end
endmodule